// File: doc/BRIEF.md
# Key-Locked Memory Controller Configuration Register Bank

This block is the software-visible configuration space of a DRAM controller. It holds a bank of 32-bit registers behind a plain word-access bus made of a byte address, a write enable, write data and combinational read data. Word 0 is a protection key register, word 1 is the controller configuration register, and the remaining words are general-purpose storage. Writes to anything except the key register are dropped unless the key register currently holds one exact unlock value. Software therefore unlocks the bank, changes the configuration, and then writes any other value to the key to lock it again.

The configuration register keeps some bit fields read-only. Which fields are read-only depends on a static silicon revision select input. On reset the configuration register is preloaded with revision-specific defaults, including an encoded DRAM size field. The bank derives that field from a static input that gives the fitted DRAM size in megabytes.

Top module: `memctl_cfg_regs`

## Requirements
- R1: The word index is `busAddr[11:2]`. `busAddr[1:0]` has no effect. The key register is at byte 0x000, the configuration register is at 0x004, and general registers follow at 0x008 onward.
- R2: While the key register differs from 0xFC600309, a write to any in-range register other than the key leaves that register unchanged.
- R3: The key register accepts every write, whether the bank is locked or unlocked, and it reads back the written value. Writing any other value re-locks the bank.
- R4: With the default of 8 registers, an access whose word index is 8 or more reads 0, and a write to it changes no register.
- R5: When the revision select is the older revision, configuration bits 31:11, 6 and 3:2 keep their stored value on a write.
- R6: When the revision select is the newer revision, configuration bits 31:28, 19:14, 6 and 3:2 keep their stored value on a write.
- R7: On reset every register clears to 0, except the configuration register. For the older revision it takes 0x40 | size code. For the newer revision it takes 0x1000000C | size code.
- R8: The size code in configuration bits 1:0 encodes the DRAM size. For the older revision, 64/128/256/512 MB give codes 0/1/2/3. For the newer revision, 128/256/512/1024 MB give codes 0/1/2/3. Any other size gives code 2.
- R9: A revision select of 1 selects the newer revision. The values 0, 2 and 3 all behave as the older revision.
- R10: An unlocked write becomes visible on the read port after the next rising clock edge. General registers store all 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| revSel | input | 2 | Static silicon revision select (1 = newer) |
| dramSizeMb | input | 12 | Static fitted DRAM size in MB |
| busAddr | input | 12 | Byte address of the access |
| busWe | input | 1 | Write enable for the current cycle |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data |

## Verification
The bench goes after the lock boundary with a key that is one bit short of the unlock value. A design that compared only part of the key would accept writes there. It writes past the end of the array at a word index that aliases the key register if the index is truncated. A truncating design would overwrite the key and silently re-lock the bank. It writes all-ones and then all-zeros to the configuration register under both revisions. That exposes a mask that zeroes read-only fields instead of holding them, and a mask taken from the wrong revision. Off-list sizes and revision selects 2 and 3 check the fallback decode. A design that defaulted per revision, or treated any nonzero select as the newer revision, would load the wrong reset value.

// File: rtl/memctl_cfg_pkg.sv
package memctl_cfg_pkg;

  localparam logic [31:0] UNLOCK_KEY  = 32'hFC60_0309;
  localparam logic [31:0] RO_MASK_OLD = 32'hFFFF_F84C;
  localparam logic [31:0] RO_MASK_NEW = 32'hF00F_C04C;
  localparam logic [31:0] INIT_OLD    = 32'h0000_0040;
  localparam logic [31:0] INIT_NEW    = 32'h1000_000C;

  typedef struct packed {
    logic keyWr;
    logic cfgWr;
    logic genWr;
    logic rdHit;
  } regStrobes_t;

  function automatic logic isNewerRev(input logic [1:0] rev);
    return rev == 2'd1;
  endfunction

  function automatic logic [1:0] sizeCode(input logic newer, input logic [11:0] mb);
    logic [1:0] code;
    code = 2'd2;
    if (newer) begin
      case (mb)
        12'd128:  code = 2'd0;
        12'd256:  code = 2'd1;
        12'd512:  code = 2'd2;
        12'd1024: code = 2'd3;
        default:  code = 2'd2;
      endcase
    end else begin
      case (mb)
        12'd64:  code = 2'd0;
        12'd128: code = 2'd1;
        12'd256: code = 2'd2;
        12'd512: code = 2'd3;
        default: code = 2'd2;
      endcase
    end
    return code;
  endfunction

endpackage

// File: rtl/memctl_cfg_ctrl.sv
module memctl_cfg_ctrl
  import memctl_cfg_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 8,
  localparam int WIDX_W  = ADDR_W - 2,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              keyOpen,
  output regStrobes_t       strb,
  output logic [IDX_W-1:0]  regIdx
);

  logic [WIDX_W-1:0] wordIdx;
  logic              inRange;
  logic              unusedLowBits;

  assign wordIdx       = busAddr[ADDR_W-1:2];
  assign unusedLowBits = ^busAddr[1:0];
  assign inRange       = (32'(wordIdx) < NUM_REGS);
  assign regIdx        = wordIdx[IDX_W-1:0];

  always_comb begin
    strb       = '0;
    strb.rdHit = inRange;
    if (busWe && inRange) begin
      if (wordIdx == '0)           strb.keyWr = 1'b1;
      else if (keyOpen) begin
        if (32'(wordIdx) == 1)     strb.cfgWr = 1'b1;
        else                       strb.genWr = 1'b1;
      end
    end
  end

  // R3: the key register is never blocked
  a_r3_key_always: assert property (@(posedge clk) disable iff (rst)
    (busWe && wordIdx == '0) |-> strb.keyWr);

  // R4: out-of-range accesses raise no strobe
  a_r4_oob_no_strobe: assert property (@(posedge clk) disable iff (rst)
    (32'(wordIdx) >= NUM_REGS) |-> (strb == '0));

  a_r2_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.keyWr, strb.cfgWr, strb.genWr}));

endmodule

// File: rtl/memctl_cfg_data.sv
module memctl_cfg_data
  import memctl_cfg_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS),
  localparam int GEN_N   = NUM_REGS - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        revSel,
  input  logic [11:0]       dramSizeMb,
  input  regStrobes_t       strb,
  input  logic [IDX_W-1:0]  regIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic              keyOpen,
  output logic [DATA_W-1:0] rdData
);

  logic              newerRev;
  logic [DATA_W-1:0] roMask;
  logic [DATA_W-1:0] cfgInit;
  logic [DATA_W-1:0] keyQ;
  logic [DATA_W-1:0] cfgQ;
  logic [DATA_W-1:0] genQ [GEN_N];
  logic [DATA_W-1:0] rdArr [NUM_REGS];

  assign newerRev = isNewerRev(revSel);
  assign roMask   = newerRev ? RO_MASK_NEW : RO_MASK_OLD;
  assign cfgInit  = (newerRev ? INIT_NEW : INIT_OLD)
                  | {30'd0, sizeCode(newerRev, dramSizeMb)};
  assign keyOpen  = (keyQ == UNLOCK_KEY);

  always_ff @(posedge clk) begin
    if (rst)             keyQ <= '0;
    else if (strb.keyWr) keyQ <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst)             cfgQ <= cfgInit;
    else if (strb.cfgWr) cfgQ <= (cfgQ & roMask) | (wrData & ~roMask);
  end

  for (genvar gi = 0; gi < GEN_N; gi++) begin : g_gen
    always_ff @(posedge clk) begin
      if (rst)                                     genQ[gi] <= '0;
      else if (strb.genWr && 32'(regIdx) == gi + 2) genQ[gi] <= wrData;
    end
  end

  always_comb begin
    rdArr[0] = keyQ;
    rdArr[1] = cfgQ;
    for (int i = 2; i < NUM_REGS; i++) rdArr[i] = genQ[i-2];
  end

  assign rdData = strb.rdHit ? rdArr[regIdx] : '0;

  // R2: no configuration or general write strobe while locked
  a_r2_locked_gate: assert property (@(posedge clk) disable iff (rst)
    (strb.cfgWr || strb.genWr) |-> keyOpen);

  // R5/R6: read-only configuration fields survive a write
  a_r5_ro_fields_held: assert property (@(posedge clk) disable iff (rst)
    strb.cfgWr |=> ((cfgQ & roMask) == ($past(cfgQ) & roMask)));

  // R7: configuration default right after reset
  a_r7_cfg_default: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfgQ == cfgInit && keyQ == '0));

  a_r3_relock: assert property (@(posedge clk) disable iff (rst)
    (strb.keyWr && wrData != UNLOCK_KEY) |=> !keyOpen);

endmodule

// File: rtl/memctl_cfg_regs.sv
module memctl_cfg_regs
  import memctl_cfg_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        revSel,
  input  logic [11:0]       dramSizeMb,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata
);

  regStrobes_t      strb;
  logic [IDX_W-1:0] regIdx;
  logic             keyOpen;

  memctl_cfg_ctrl #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_ctrl (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busWe(busWe),
    .keyOpen(keyOpen), .strb(strb), .regIdx(regIdx)
  );

  memctl_cfg_data #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rst(rst), .revSel(revSel), .dramSizeMb(dramSizeMb),
    .strb(strb), .regIdx(regIdx), .wrData(busWdata),
    .keyOpen(keyOpen), .rdData(busRdata)
  );

  // R4: reads beyond the array return zero
  a_r4_oob_read_zero: assert property (@(posedge clk) disable iff (rst)
    (32'(busAddr[ADDR_W-1:2]) >= NUM_REGS) |-> (busRdata == '0));

endmodule

// File: tb/memctl_cfg_regs_bench.sv
module memctl_cfg_regs_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] KEY = 32'hFC60_0309;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  revSel = 2'd0;
  logic [11:0] dramSizeMb = 12'd256;
  logic [11:0] busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memctl_cfg_regs u_memctl_cfg_regs (
    .clk(clk), .rst(rst), .revSel(revSel), .dramSizeMb(dramSizeMb),
    .busAddr(busAddr), .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata)
  );

  task automatic doReset(input logic [1:0] rev, input logic [11:0] mb);
    @(negedge clk);
    revSel = rev; dramSizeMb = mb; rst = 1'b1; busWe = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic expectRead(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    busAddr = a;
    #1;
    total++;
    if (busRdata !== exp) begin
      bad++;
      $display("FAIL %s addr=%h actual=%h expected=%h", req, a, busRdata, exp);
    end
  endtask

  task automatic testResetOld;
    doReset(2'd0, 12'd256);
    expectRead(12'h004, 32'h0000_0042, "R7");
    expectRead(12'h000, 32'h0, "R7");
    expectRead(12'h010, 32'h0, "R7");
  endtask

  task automatic testLock;
    doWrite(12'h004, 32'hFFFF_FFFF);
    expectRead(12'h004, 32'h0000_0042, "R2");
    doWrite(12'h00C, 32'h1234_5678);
    expectRead(12'h00C, 32'h0, "R2");
    doWrite(12'h000, KEY ^ 32'h1);
    doWrite(12'h00C, 32'h1234_5678);
    expectRead(12'h00C, 32'h0, "R2");
  endtask

  task automatic testUnlockAndRelock;
    doWrite(12'h000, KEY);
    expectRead(12'h000, KEY, "R3");
    doWrite(12'h00C, 32'hA5A5_5A5A);
    expectRead(12'h00C, 32'hA5A5_5A5A, "R10");
    doWrite(12'h01C, 32'hFFFF_FFFF);
    expectRead(12'h01C, 32'hFFFF_FFFF, "R10");
    doWrite(12'h000, 32'h1234_5678);
    expectRead(12'h000, 32'h1234_5678, "R3");
    doWrite(12'h00C, 32'h0);
    expectRead(12'h00C, 32'hA5A5_5A5A, "R3");
    doWrite(12'h000, KEY);
  endtask

  task automatic testMaskOld;
    doWrite(12'h004, 32'hFFFF_FFFF);
    expectRead(12'h004, 32'h0000_07F3, "R5");
    doWrite(12'h004, 32'h0);
    expectRead(12'h004, 32'h0000_0040, "R5");
  endtask

  task automatic testOutOfRange;
    doWrite(12'h020, 32'h0);
    expectRead(12'h000, KEY, "R4");
    expectRead(12'h020, 32'h0, "R4");
    expectRead(12'hFFC, 32'h0, "R4");
    doWrite(12'h028, 32'h0);
    expectRead(12'h008, 32'h0, "R4");
  endtask

  task automatic testLowBits;
    doWrite(12'h00E, 32'h0000_0011);
    expectRead(12'h00C, 32'h0000_0011, "R1");
    expectRead(12'h00B, 32'h0, "R1");
    expectRead(12'h009, 32'h0, "R1");
  endtask

  task automatic testNewer;
    doReset(2'd1, 12'd1024);
    expectRead(12'h004, 32'h1000_000F, "R7");
    doWrite(12'h000, KEY);
    doWrite(12'h004, 32'hFFFF_FFFF);
    expectRead(12'h004, 32'h1FF0_3FBF, "R6");
    doWrite(12'h004, 32'h0);
    expectRead(12'h004, 32'h1000_000C, "R6");
  endtask

  task automatic testSizes;
    doReset(2'd0, 12'd64);
    expectRead(12'h004, 32'h0000_0040, "R8");
    doReset(2'd0, 12'd512);
    expectRead(12'h004, 32'h0000_0043, "R8");
    doReset(2'd0, 12'd100);
    expectRead(12'h004, 32'h0000_0042, "R8");
    doReset(2'd1, 12'd128);
    expectRead(12'h004, 32'h1000_000C, "R8");
    doReset(2'd1, 12'd300);
    expectRead(12'h004, 32'h1000_000E, "R8");
    doReset(2'd1, 12'd64);
    expectRead(12'h004, 32'h1000_000E, "R8");
  endtask

  task automatic testRevFallback;
    doReset(2'd3, 12'd128);
    expectRead(12'h004, 32'h0000_0041, "R9");
    doReset(2'd2, 12'd1024);
    expectRead(12'h004, 32'h0000_0042, "R9");
    doWrite(12'h000, KEY);
    doWrite(12'h004, 32'hFFFF_FFFF);
    expectRead(12'h004, 32'h0000_07F3, "R9");
  endtask

  initial begin
    testResetOld();
    testLock();
    testUnlockAndRelock();
    testMaskOld();
    testOutOfRange();
    testLowBits();
    testNewer();
    testSizes();
    testRevFallback();
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule